// File: doc/BRIEF.md
# Multi-Interface Bring-Up Ready Aggregator

Two source-synchronous I/O interfaces share one I/O bank. Each interface has its own control clock and its own bring-up sequencer. The two sequencers share bank-level controls, so they have to start together. This block ANDs the lock indications of both PLLs into one combined lock. It re-times that combined lock separately into each control clock, and the result becomes that interface's sequencer start.

The two control clocks may differ by up to a factor of four. Each sequencer can finish at a different time. The block ANDs the per-interface done flags, together with the combined lock, into one interface-ready flag. It then re-times that flag into the application clock domain.

The application-domain ready drives every tri-state byte control bit of every transmit interface. It also gates the receive FIFO read enable. That read enable comes from the inverted empty flag of the farthest receive lane on the clock backbone. It passes through a register stage that a parameter selects, and it is fanned out to every used receive lane.

Top module: `brup_aggregator`

## Requirements
- R1: Both sequencer starts stay low unless both PLL lock inputs are high. With both locks high, both starts assert.
- R2: Each sequencer start (`seq_start[i]`) equals the combined lock re-timed by two rising edges of its own control clock (`ctl_clk[i]`). Index 0 is interface 1 and index 1 is interface 2. Operation holds with a 4:1 ratio between the two control clocks.
- R3: `intf_ready` is high only when all of the following hold, re-timed by two `app_clk` edges: both done flags are high and both locks are high. With one done flag low, it stays low.
- R4: When either lock drops, both starts deassert within two edges of their own clocks. `intf_ready` deasserts within two `app_clk` edges.
- R5: Every bit of `tx_tbyte` equals `intf_ready`. Transmit interface k owns bits 4k to 4k+3.
- R6: No `rx_rd_en` bit is high unless `intf_ready` was high at the previous `app_clk` edge (registered variant, the default).
- R7: One `app_clk` edge after `intf_ready` is high and `rx_fifo_empty[FAR_LANE]` is low, `rx_rd_en` equals `LANE_USED`. Otherwise `rx_rd_en` is zero.
- R8: The empty flags of lanes other than `FAR_LANE` have no effect on `rx_rd_en`.
- R9: A lane whose `LANE_USED` bit is 0 never gets its read enable asserted.
- R10: Resets are synchronous and active-low, one per domain. A clock edge with a domain's reset low clears that domain's outputs: starts, `intf_ready`, `tx_tbyte` and `rx_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | NUM_IF | Control clock per interface |
| ctl_rst_n | input | NUM_IF | Synchronous active-low reset per control domain |
| app_clk | input | 1 | Application clock |
| app_rst_n | input | 1 | Synchronous active-low reset, application domain |
| pll_lock | input | NUM_IF | PLL lock per interface, asynchronous |
| seq_done | input | NUM_IF | Sequencer done per interface, asynchronous to app_clk |
| seq_start | output | NUM_IF | Sequencer start per interface, in its control domain |
| intf_ready | output | 1 | Combined interface ready, app_clk domain |
| tx_tbyte | output | 4*NUM_TX_IF | Tri-state byte controls of all transmit interfaces |
| rx_fifo_empty | input | NUM_RX_LANES | Receive FIFO empty flags per lane |
| rx_rd_en | output | NUM_RX_LANES | Receive FIFO read enables per lane |

## Verification
On every cycle of its own domain, the in-RTL properties check the following:
- a start or ready rises only after its source condition was present two edges earlier;
- a lost lock forces these outputs low;
- a read enable never appears without ready on the edge before;
- a nonempty farthest lane under ready produces the used-lane enable pattern;
- reset clears the outputs.

Other behaviours need the bench's scenarios and its clock-by-clock model, with three free-running clocks (200 MHz, 50 MHz and 50 MHz at a different phase). These are:
- the ready staying low while only one sequencer has finished;
- the irrelevance of the other lanes' empty flags;
- the permanently disabled unused lane;
- the 4:1 control-clock ratio.

// File: rtl/brup_pkg.sv
// Shared constants for the bring-up ready aggregator.
// Assumes: each transmit interface exposes one 4-bit tri-state byte control.
package brup_pkg;
    localparam int unsigned TBYTE_W   = 4;
    localparam int unsigned MIN_SYNC  = 2;
endpackage

// File: rtl/brup_sync.sv
// Level synchronizer: moves a slowly changing level into the clk domain.
// Assumes: d is held stable for several clk periods; rst_n is synchronous
// to clk and active-low; STAGES >= 2.
module brup_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the sampled level through the flop chain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/brup_tx_fan.sv
// Fans the application-domain ready out to every transmit tri-state byte.
// Assumes: ready is already synchronous to the application clock.
module brup_tx_fan #(
    parameter int unsigned NUM_TX = 2,
    parameter int unsigned W      = 4,
    localparam int unsigned OUT_W = NUM_TX * W
) (
    input  logic             ready,
    output logic [OUT_W-1:0] tbyte
);
    for (genvar k = 0; k < NUM_TX; k++) begin : g_if
        // Drive all bits of interface k from the shared ready.
        assign tbyte[k*W +: W] = {W{ready}};
    end
endmodule

// File: rtl/brup_rd_gate.sv
// Receive read-enable gate: enables all used lanes while ready is high and
// the farthest lane's FIFO holds data; optional output register.
// Assumes: fifo_empty and ready are synchronous to clk; FAR < LANES.
module brup_rd_gate #(
    parameter int unsigned         LANES = 6,
    parameter int unsigned         FAR   = 5,
    parameter logic [LANES-1:0]    USED  = '1,
    parameter bit                  REG   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic [LANES-1:0] fifo_empty,
    output logic [LANES-1:0] rd_en
);
    logic take;

    // Read is permitted only with ready high and data in the farthest lane.
    assign take = ready & ~fifo_empty[FAR];

    if (REG) begin : g_reg
        logic take_q;

        // Register the permission for timing relief toward the lanes.
        always_ff @(posedge clk) begin
            if (!rst_n) take_q <= 1'b0;
            else        take_q <= take;
        end

        assign rd_en = take_q ? USED : '0;

        // R6
        rd_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (|rd_en) |-> $past(ready));

        // R7
        rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ready && !fifo_empty[FAR]) |=> (rd_en == USED));
    end else begin : g_comb
        assign rd_en = take ? USED : '0;
    end
endmodule

// File: rtl/brup_aggregator.sv
// Bring-up ready aggregator for interfaces sharing one I/O bank.
// Combines PLL locks, re-times the result into each control clock as the
// sequencer start, merges done flags with lock into one ready re-timed to
// the application clock, and drives transmit tri-state bytes and receive
// read enables from it.
// Assumes: control clocks within 4:1 of each other; one synchronous
// active-low reset per domain; inputs change slowly relative to clocks.
module brup_aggregator
    import brup_pkg::*;
#(
    parameter int unsigned              NUM_IF       = 2,
    parameter int unsigned              NUM_TX_IF    = 2,
    parameter int unsigned              NUM_RX_LANES = 6,
    parameter int unsigned              FAR_LANE     = 5,
    parameter logic [NUM_RX_LANES-1:0]  LANE_USED    = 6'b110111,
    parameter bit                       RD_EN_REG    = 1'b1,
    parameter int unsigned              SYNC_STAGES  = MIN_SYNC,
    localparam int unsigned             TX_W         = NUM_TX_IF * TBYTE_W
) (
    input  logic [NUM_IF-1:0]       ctl_clk,
    input  logic [NUM_IF-1:0]       ctl_rst_n,
    input  logic                    app_clk,
    input  logic                    app_rst_n,
    input  logic [NUM_IF-1:0]       pll_lock,
    input  logic [NUM_IF-1:0]       seq_done,
    output logic [NUM_IF-1:0]       seq_start,
    output logic                    intf_ready,
    output logic [TX_W-1:0]         tx_tbyte,
    input  logic [NUM_RX_LANES-1:0] rx_fifo_empty,
    output logic [NUM_RX_LANES-1:0] rx_rd_en
);
    logic lock_all;
    logic ready_raw;

    // Combined lock and combined ready source, before any re-timing.
    assign lock_all  = &pll_lock;
    assign ready_raw = (&seq_done) & lock_all;

    for (genvar g = 0; g < NUM_IF; g++) begin : g_ctl
        // Re-time the combined lock into control domain g.
        brup_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
            .clk   (ctl_clk[g]),
            .rst_n (ctl_rst_n[g]),
            .d     (lock_all),
            .q     (seq_start[g])
        );

        if (SYNC_STAGES == 2) begin : g_chk
            // R2
            start_src_chk: assert property (@(posedge ctl_clk[g])
                disable iff (!ctl_rst_n[g])
                $rose(seq_start[g]) |-> $past(lock_all, 2));

            // R4
            start_drop_chk: assert property (@(posedge ctl_clk[g])
                disable iff (!ctl_rst_n[g])
                !$past(lock_all, 2) |-> !seq_start[g]);
        end

        // R10
        start_reset_chk: assert property (@(posedge ctl_clk[g])
            !ctl_rst_n[g] |=> !seq_start[g]);
    end

    // Re-time the merged ready into the application domain.
    brup_sync #(.STAGES(SYNC_STAGES)) u_ready_sync (
        .clk   (app_clk),
        .rst_n (app_rst_n),
        .d     (ready_raw),
        .q     (intf_ready)
    );

    brup_tx_fan #(.NUM_TX(NUM_TX_IF), .W(TBYTE_W)) u_tx_fan (
        .ready (intf_ready),
        .tbyte (tx_tbyte)
    );

    brup_rd_gate #(
        .LANES (NUM_RX_LANES),
        .FAR   (FAR_LANE),
        .USED  (LANE_USED),
        .REG   (RD_EN_REG)
    ) u_rd_gate (
        .clk        (app_clk),
        .rst_n      (app_rst_n),
        .ready      (intf_ready),
        .fifo_empty (rx_fifo_empty),
        .rd_en      (rx_rd_en)
    );

    if (SYNC_STAGES == 2) begin : g_app_chk
        // R3
        ready_src_chk: assert property (@(posedge app_clk)
            disable iff (!app_rst_n)
            $rose(intf_ready) |-> $past(ready_raw, 2));

        // R4
        ready_drop_chk: assert property (@(posedge app_clk)
            disable iff (!app_rst_n)
            !$past(lock_all, 2) |-> !intf_ready);
    end

    // R10
    app_reset_chk: assert property (@(posedge app_clk)
        !app_rst_n |=> (!intf_ready && rx_rd_en == '0 && tx_tbyte == '0));
endmodule

// File: tb/sim_brup_aggregator.sv
`timescale 1ns/100ps
module sim_brup_aggregator;
    localparam int NIF = 2;
    localparam int NTX = 2;
    localparam int NL  = 6;
    localparam int FAR = 5;
    localparam logic [NL-1:0] USED = 6'b110111;

    logic [NIF-1:0]  ctl_clk = '0;
    logic [NIF-1:0]  ctl_rst_n = '0;
    logic            app_clk = 1'b0;
    logic            app_rst_n = 1'b0;
    logic [NIF-1:0]  pll_lock = '0;
    logic [NIF-1:0]  seq_done = '0;
    logic [NIF-1:0]  seq_start;
    logic            intf_ready;
    logic [NTX*4-1:0] tx_tbyte;
    logic [NL-1:0]   rx_fifo_empty = '1;
    logic [NL-1:0]   rx_rd_en;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    brup_aggregator u0 (
        .ctl_clk(ctl_clk), .ctl_rst_n(ctl_rst_n), .app_clk(app_clk),
        .app_rst_n(app_rst_n), .pll_lock(pll_lock), .seq_done(seq_done),
        .seq_start(seq_start), .intf_ready(intf_ready), .tx_tbyte(tx_tbyte),
        .rx_fifo_empty(rx_fifo_empty), .rx_rd_en(rx_rd_en)
    );

    // Control clock 1 at 200 MHz, control clock 2 at 50 MHz (4:1),
    // application clock at 50 MHz with its own phase.
    initial forever #2.5 ctl_clk[0] = ~ctl_clk[0];
    initial begin #1; forever #10 ctl_clk[1] = ~ctl_clk[1]; end
    initial forever #10 app_clk = ~app_clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: histories of sampled values per domain.
    bit h0[$], h1[$], ha[$];
    bit rd_exp = 0;
    initial begin h0 = {0, 0}; h1 = {0, 0}; ha = {0, 0}; end

    always @(posedge ctl_clk[0]) begin
        if (!ctl_rst_n[0]) h0 = {0, 0};
        else begin h0.push_back(&pll_lock); void'(h0.pop_front()); end
    end
    always @(posedge ctl_clk[1]) begin
        if (!ctl_rst_n[1]) h1 = {0, 0};
        else begin h1.push_back(&pll_lock); void'(h1.pop_front()); end
    end
    always @(posedge app_clk) begin
        if (!app_rst_n) begin ha = {0, 0}; rd_exp = 0; end
        else begin
            rd_exp = ha[0] & ~rx_fifo_empty[FAR];
            ha.push_back((&seq_done) & (&pll_lock));
            void'(ha.pop_front());
        end
    end

    // Per-clock comparisons against the model (R2, R3, R5, R7).
    always @(negedge ctl_clk[0])
        chk(seq_start[0] == h0[0], "R2 start1", seq_start[0], h0[0]);
    always @(negedge ctl_clk[1])
        chk(seq_start[1] == h1[0], "R2 start2", seq_start[1], h1[0]);
    always @(negedge app_clk) begin
        chk(intf_ready == ha[0], "R3 ready", intf_ready, ha[0]);
        chk(tx_tbyte == {(NTX*4){ha[0]}}, "R5 tbyte", tx_tbyte, {(NTX*4){ha[0]}});
        chk(rx_rd_en == (rd_exp ? USED : '0), "R7 rd_en", rx_rd_en, rd_exp ? USED : '0);
    end

    task automatic drive_slot();
        @(negedge app_clk); #4;
    endtask
    task automatic settle(input int n);
        repeat (n) @(negedge app_clk);
    endtask

    initial begin
        pll_lock = 2'b11;
        settle(4);
        // R10: outputs low while resets held, even with locks high
        chk(seq_start == 2'b00, "R10 start in reset", seq_start, 0);
        chk(intf_ready == 1'b0 && rx_rd_en == '0 && tx_tbyte == '0,
            "R10 app outputs in reset", {intf_ready, rx_rd_en}, 0);
        drive_slot();
        ctl_rst_n = 2'b11; app_rst_n = 1'b1; pll_lock = 2'b01;
        settle(6);
        // R1: one lock missing keeps both starts low
        chk(seq_start == 2'b00, "R1 one lock low", seq_start, 0);
        drive_slot(); pll_lock = 2'b11;
        settle(4);
        // R1, R2: both locks give both starts at a 4:1 clock ratio
        chk(seq_start == 2'b11, "R1 R2 both starts", seq_start, 3);
        drive_slot(); seq_done = 2'b01;
        settle(6);
        // R3: ready held low with one done flag low
        chk(intf_ready == 1'b0, "R3 partial done", intf_ready, 0);
        drive_slot(); seq_done = 2'b11;
        settle(4);
        chk(intf_ready == 1'b1, "R3 all done", intf_ready, 1);
        // R5: every tri-state byte bit follows ready
        chk(tx_tbyte == '1, "R5 tbyte high", tx_tbyte, 8'hFF);
        chk(rx_rd_en == '0, "R7 far lane empty", rx_rd_en, 0);
        drive_slot(); rx_fifo_empty = 6'b011111;
        settle(3);
        // R7, R9: far lane data enables used lanes only
        chk(rx_rd_en == USED, "R7 far lane data", rx_rd_en, USED);
        chk(rx_rd_en[3] == 1'b0, "R9 unused lane", rx_rd_en[3], 0);
        drive_slot(); rx_fifo_empty = 6'b100000;
        settle(3);
        // R8: other lanes' data does not enable reads
        chk(rx_rd_en == '0, "R8 other lanes ignored", rx_rd_en, 0);
        drive_slot(); rx_fifo_empty = 6'b000000;
        settle(3);
        chk(rx_rd_en == USED, "R8 all nonempty", rx_rd_en, USED);
        drive_slot(); seq_done = 2'b10;
        settle(4);
        // R6: no read enable without ready
        chk(intf_ready == 1'b0 && rx_rd_en == '0, "R6 no rd without ready",
            {intf_ready, rx_rd_en}, 0);
        drive_slot(); seq_done = 2'b11;
        settle(4);
        chk(rx_rd_en == USED, "R7 ready back", rx_rd_en, USED);
        drive_slot(); pll_lock = 2'b10;
        settle(3);
        // R4: lock loss drops starts, ready and reads
        chk(seq_start == 2'b00, "R4 starts drop", seq_start, 0);
        chk(intf_ready == 1'b0 && rx_rd_en == '0, "R4 ready drops",
            {intf_ready, rx_rd_en}, 0);
        drive_slot(); pll_lock = 2'b11;
        settle(4);
        chk(intf_ready == 1'b1, "R4 relock", intf_ready, 1);
        drive_slot(); app_rst_n = 1'b0;
        settle(2);
        // R10: application reset mid-run clears its outputs
        chk(intf_ready == 1'b0 && rx_rd_en == '0 && tx_tbyte == '0,
            "R10 app reset", {intf_ready, rx_rd_en}, 0);
        chk(seq_start == 2'b11, "R10 ctl unaffected", seq_start, 3);
        drive_slot(); app_rst_n = 1'b1;
        settle(6);
        chk(rx_rd_en == USED, "R7 after reset", rx_rd_en, USED);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule